// File: doc/BRIEF.md
# Two-Way Processor Mailbox with Word Queues and Doorbells

This block links two processors, called side A and side B, that share one clock. Each side has a small register port with four word registers: a sync register, a control and status register, a send register and a receive register. A word that one side writes to its send register enters a queue that belongs to that side. The other side reads the word from its own receive register. There is one such queue in each direction, and each queue holds DEPTH words.

The two sides also exchange one byte that does not pass through the queues. Each side writes the byte it offers in its sync register, and the other side reads that byte back. Either side can ring a doorbell that raises an interrupt on the other processor. The other processor must have enabled that interrupt. Each side also has level interrupts for two conditions: its outgoing queue has drained, or its incoming queue holds data. A sticky error flag records accesses that went wrong. Software can flush a side's outgoing queue.

Access works as follows. Software drives `x_addr` and pulses `x_wr` or `x_rd` for one cycle. Read data appears on `x_rdata` in the same cycle, decoded straight from `x_addr`. A read of the receive register removes the word at the clock edge that ends the access. Register index (`x_addr`): 0 is sync, 1 is control, 2 is send, 3 is receive.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, control reads 0x0101 on both sides: only bit 0 (outgoing queue empty) and bit 8 (incoming queue empty) are set. Sync reads 0 on both sides, and both irq outputs are low.
- R2: Words written to a side's send register are read back from the other side's receive register in the order they were written. This holds in both directions.
- R3: Control bit 1 (outgoing queue full) sets once DEPTH words are queued. The peer's control bit 9 (incoming queue full) sets at the same point. Bit 0 and bit 8 clear while a queue holds data.
- R4: A write to the send register while the outgoing queue is full is dropped and sets control bit 14. Writing control with bit 14 = 1 clears that bit.
- R5: A receive read from an empty queue returns the last word read, sets control bit 14, and leaves the queue unchanged.
- R6: While control bit 15 is 0, send writes and receive reads do not change either queue and do not set bit 14. A receive read still returns the head word.
- R7: Writing control with bit 3 = 1 empties that side's outgoing queue. A control write with bit 3 = 0 leaves the queue untouched.
- R8: Sync bits 15:8 hold the byte the local side offers. The peer reads the same byte in its sync bits 7:0. Sync writes obey `x_be`: lane 1 updates bits 15:8, and lane 3 updates bit 31 and carries the doorbell bits.
- R9: Side A writing sync bit 29 (with lane 3 enabled) makes `b_irq` pulse high for exactly one cycle, after the edge, if B's sync bit 31 is 1. Side B writing sync bit 30 does the same for `a_irq`. With the target's bit 31 = 0, no pulse occurs. Writing the other side's ring bit does nothing.
- R10: Control bit 2 makes `x_irq` high while the outgoing queue is empty. Control bit 10 makes `x_irq` high while the incoming queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| a_addr | input | 2 | Side A register index |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe |
| a_be | input | 4 | Side A byte-lane enables, used for sync writes |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data for the addressed register |
| a_irq | output | 1 | Interrupt to processor A |
| b_addr | input | 2 | Side B register index |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe |
| b_be | input | 4 | Side B byte-lane enables, used for sync writes |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data for the addressed register |
| b_irq | output | 1 | Interrupt to processor B |

## Verification
The bench fills a queue to DEPTH and then writes one word more. A design that accepted the extra word would return it on the peer's reads, and one that missed the error would read bit 14 as clear. The bench also reads an empty queue and then pushes a new word. A design that moved its pointers on the empty read would return the wrong word afterwards, or an empty-looking queue. With bit 15 clear, the bench checks that neither queue moves. It also checks that a flush happens only when bit 3 = 1. For the doorbell, the bench checks that the pulse is one cycle wide, that it goes to the correct side, and that the enable bit gates it.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        REG_SYNC = 2'd0,
        REG_CTRL = 2'd1,
        REG_SEND = 2'd2,
        REG_RECV = 2'd3
    } reg_sel_e;

    // control bit positions (decoded by software on both sides)
    localparam int CB_TX_EMPTY = 0;
    localparam int CB_TX_FULL  = 1;
    localparam int CB_TXE_IE   = 2;
    localparam int CB_FLUSH    = 3;
    localparam int CB_RX_EMPTY = 8;
    localparam int CB_RX_FULL  = 9;
    localparam int CB_RXNE_IE  = 10;
    localparam int CB_ERR      = 14;
    localparam int CB_QEN      = 15;
    localparam int SB_IE       = 31;

    typedef struct packed {
        logic txe_ie;
        logic rxne_ie;
        logic err;
        logic q_en;
    } ctrl_t;

    typedef struct packed {
        logic empty;
        logic full;
    } qstat_t;

    function automatic logic [WORD_W-1:0] pack_ctrl(ctrl_t c, qstat_t tx, qstat_t rx);
        logic [WORD_W-1:0] v;
        v = '0;
        v[CB_TX_EMPTY] = tx.empty;
        v[CB_TX_FULL]  = tx.full;
        v[CB_TXE_IE]   = c.txe_ie;
        v[CB_RX_EMPTY] = rx.empty;
        v[CB_RX_FULL]  = rx.full;
        v[CB_RXNE_IE]  = c.rxne_ie;
        v[CB_ERR]      = c.err;
        v[CB_QEN]      = c.q_en;
        return v;
    endfunction
endpackage

// File: rtl/ipc_fifo.sv
module ipc_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_drop_when_full_R4: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> full);
    assert_pop_empty_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push && !flush) |=> empty);
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);
endmodule

// File: rtl/ipc_port.sv
module ipc_port
    import ipc_pkg::*;
#(
    parameter int RING_BIT = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [3:0]        be,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq,
    input  qstat_t            tx_stat,
    input  qstat_t            rx_stat,
    input  logic [WORD_W-1:0] rx_head,
    input  logic [7:0]        peer_byte,
    input  logic              peer_ring,
    output logic              push,
    output logic              pop,
    output logic              flush,
    output logic [7:0]        my_byte,
    output logic              ring_out
);
    reg_sel_e          sel;
    ctrl_t             ctrl;
    logic              irq_en, db_pulse;
    logic [WORD_W-1:0] last_rd;
    logic              wr_sync, wr_ctrl, wr_send, rd_recv, err_set;
    logic              unused_lanes;

    assign sel     = reg_sel_e'(addr);
    assign wr_sync = wr && (sel == REG_SYNC);
    assign wr_ctrl = wr && (sel == REG_CTRL);
    assign wr_send = wr && (sel == REG_SEND);
    assign rd_recv = rd && (sel == REG_RECV);

    assign push     = wr_send && ctrl.q_en && !tx_stat.full;
    assign pop      = rd_recv && ctrl.q_en && !rx_stat.empty;
    assign flush    = wr_ctrl && wdata[CB_FLUSH];
    assign ring_out = wr_sync && be[3] && wdata[RING_BIT];
    assign err_set  = ctrl.q_en && ((wr_send && tx_stat.full) || (rd_recv && rx_stat.empty));
    assign unused_lanes = be[0] ^ be[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            irq_en   <= 1'b0;
            my_byte  <= '0;
            last_rd  <= '0;
            db_pulse <= 1'b0;
        end else begin
            if (wr_sync && be[1]) my_byte <= wdata[15:8];
            if (wr_sync && be[3]) irq_en  <= wdata[SB_IE];
            if (wr_ctrl) begin
                ctrl.txe_ie  <= wdata[CB_TXE_IE];
                ctrl.rxne_ie <= wdata[CB_RXNE_IE];
                ctrl.q_en    <= wdata[CB_QEN];
            end
            if (err_set)                      ctrl.err <= 1'b1;
            else if (wr_ctrl && wdata[CB_ERR]) ctrl.err <= 1'b0;
            if (pop) last_rd <= rx_head;
            db_pulse <= peer_ring && irq_en;
        end
    end

    always_comb begin
        unique case (sel)
            REG_SYNC: rdata = {irq_en, 15'd0, my_byte, peer_byte};
            REG_CTRL: rdata = pack_ctrl(ctrl, tx_stat, rx_stat);
            REG_SEND: rdata = '0;
            default:  rdata = rx_stat.empty ? last_rd : rx_head;
        endcase
    end

    assign irq = db_pulse || (ctrl.txe_ie && tx_stat.empty) || (ctrl.rxne_ie && !rx_stat.empty);

    assert_err_on_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_send && ctrl.q_en && tx_stat.full) |=> ctrl.err);
    assert_err_on_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_recv && ctrl.q_en && rx_stat.empty) |=> ctrl.err);
    assert_doorbell_cause_R9: assert property (@(posedge clk) disable iff (rst)
        db_pulse |-> $past(peer_ring && irq_en));
    assert_disabled_no_move_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.q_en |-> (!push && !pop));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  a_addr,
    input  logic        a_wr,
    input  logic        a_rd,
    input  logic [3:0]  a_be,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_irq,
    input  logic [1:0]  b_addr,
    input  logic        b_wr,
    input  logic        b_rd,
    input  logic [3:0]  b_be,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_irq
);
    localparam int SIDES = 2;

    logic [1:0]        s_addr  [SIDES];
    logic              s_wr    [SIDES];
    logic              s_rd    [SIDES];
    logic [3:0]        s_be    [SIDES];
    logic [WORD_W-1:0] s_wdata [SIDES];
    logic [WORD_W-1:0] s_rdata [SIDES];
    logic              s_irq   [SIDES];
    logic [WORD_W-1:0] q_head  [SIDES];
    qstat_t            q_stat  [SIDES];
    logic              q_push  [SIDES];
    logic              rx_pop  [SIDES];
    logic              q_flush [SIDES];
    logic [7:0]        s_byte  [SIDES];
    logic              s_ring  [SIDES];

    assign s_addr[0] = a_addr;  assign s_addr[1] = b_addr;
    assign s_wr[0]   = a_wr;    assign s_wr[1]   = b_wr;
    assign s_rd[0]   = a_rd;    assign s_rd[1]   = b_rd;
    assign s_be[0]   = a_be;    assign s_be[1]   = b_be;
    assign s_wdata[0] = a_wdata; assign s_wdata[1] = b_wdata;
    assign a_rdata = s_rdata[0]; assign b_rdata = s_rdata[1];
    assign a_irq   = s_irq[0];   assign b_irq   = s_irq[1];

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int PEER = SIDES - 1 - s;

        // queue s carries words from side s to its peer
        ipc_fifo #(.DEPTH(DEPTH), .WIDTH(WORD_W)) u_queue (
            .clk       (clk),
            .rst       (rst),
            .push      (q_push[s]),
            .push_data (s_wdata[s]),
            .pop       (rx_pop[PEER]),
            .flush     (q_flush[s]),
            .head      (q_head[s]),
            .empty     (q_stat[s].empty),
            .full      (q_stat[s].full)
        );

        ipc_port #(.RING_BIT(s == 0 ? 29 : 30)) u_port (
            .clk       (clk),
            .rst       (rst),
            .addr      (s_addr[s]),
            .wr        (s_wr[s]),
            .rd        (s_rd[s]),
            .be        (s_be[s]),
            .wdata     (s_wdata[s]),
            .rdata     (s_rdata[s]),
            .irq       (s_irq[s]),
            .tx_stat   (q_stat[s]),
            .rx_stat   (q_stat[PEER]),
            .rx_head   (q_head[PEER]),
            .peer_byte (s_byte[PEER]),
            .peer_ring (s_ring[PEER]),
            .push      (q_push[s]),
            .pop       (rx_pop[s]),
            .flush     (q_flush[s]),
            .my_byte   (s_byte[s]),
            .ring_out  (s_ring[s])
        );
    end

    assert_sync_cross_R8: assert property (@(posedge clk) disable iff (rst)
        (b_addr == 2'd0) |-> (b_rdata[7:0] == $past(a_wr && a_addr == 2'd0 && a_be[1]
            ? a_wdata[15:8] : a_rdata[15:8]) || a_addr != 2'd0 || $past(a_addr) != 2'd0));
endmodule

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  a_addr = '0, b_addr = '0;
    logic        a_wr = 1'b0, a_rd = 1'b0, b_wr = 1'b0, b_rd = 1'b0;
    logic [3:0]  a_be = '0, b_be = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_mailbox #(.DEPTH(DEPTH)) u_ipc_mailbox (
        .clk(clk), .rst(rst),
        .a_addr(a_addr), .a_wr(a_wr), .a_rd(a_rd), .a_be(a_be), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_addr(b_addr), .b_wr(b_wr), .b_rd(b_rd), .b_be(b_be), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq)
    );

    typedef struct packed {
        logic        side;
        logic        is_rd;
        logic [1:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] mask;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 2'd1, 4'hF, 32'h0000_0101, 32'h0000_FFFF, 4'd1},
        '{1'b0, 1'b0, 2'd1, 4'hF, 32'h0000_8000, 32'h0,         4'd0},
        '{1'b1, 1'b0, 2'd1, 4'hF, 32'h0000_8000, 32'h0,         4'd0},
        '{1'b0, 1'b0, 2'd2, 4'hF, 32'h1111_1111, 32'h0,         4'd0},
        '{1'b0, 1'b0, 2'd2, 4'hF, 32'h2222_2222, 32'h0,         4'd0},
        '{1'b1, 1'b1, 2'd1, 4'hF, 32'h0000_8001, 32'h0000_FFFF, 4'd3},
        '{1'b1, 1'b1, 2'd3, 4'hF, 32'h1111_1111, 32'hFFFF_FFFF, 4'd2},
        '{1'b1, 1'b1, 2'd3, 4'hF, 32'h2222_2222, 32'hFFFF_FFFF, 4'd2},
        '{1'b1, 1'b0, 2'd2, 4'hF, 32'hCAFE_F00D, 32'h0,         4'd0},
        '{1'b0, 1'b1, 2'd3, 4'hF, 32'hCAFE_F00D, 32'hFFFF_FFFF, 4'd2},
        '{1'b0, 1'b0, 2'd0, 4'h2, 32'h0000_5A00, 32'h0,         4'd0},
        '{1'b1, 1'b1, 2'd0, 4'hF, 32'h0000_005A, 32'h0000_FFFF, 4'd8},
        '{1'b0, 1'b1, 2'd0, 4'hF, 32'h0000_5A00, 32'h0000_FFFF, 4'd8},
        '{1'b0, 1'b0, 2'd0, 4'h1, 32'h0000_FF77, 32'h0,         4'd0},
        '{1'b1, 1'b1, 2'd0, 4'hF, 32'h0000_005A, 32'h0000_FFFF, 4'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic side, input logic is_rd, input logic [1:0] addr,
                       input logic [3:0] be, input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        if (!side) begin
            a_addr = addr; a_wr = !is_rd; a_rd = is_rd; a_be = be; a_wdata = d;
        end else begin
            b_addr = addr; b_wr = !is_rd; b_rd = is_rd; b_be = be; b_wdata = d;
        end
        #1 q = side ? b_rdata : a_rdata;
        @(posedge clk);
        #1;
        a_wr = 1'b0; a_rd = 1'b0; b_wr = 1'b0; b_rd = 1'b0;
    endtask

    task automatic wr(input logic side, input logic [1:0] addr, input logic [31:0] d);
        logic [31:0] q;
        acc(side, 1'b0, addr, 4'hF, d, q);
    endtask

    task automatic rd(input logic side, input logic [1:0] addr, output logic [31:0] q);
        acc(side, 1'b1, addr, 4'hF, 32'h0, q);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] q;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(1'b1, 2'd1, q); check("R1 ctrl B", q, 32'h0000_0101);
        rd(1'b0, 2'd0, q); check("R1 sync A", q, 32'h0);
        rd(1'b1, 2'd0, q); check("R1 sync B", q, 32'h0);
        check("R1 irqs", {30'd0, a_irq, b_irq}, 32'h0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            acc(VECS[i].side, VECS[i].is_rd, VECS[i].addr, VECS[i].be, VECS[i].data, q);
            if (VECS[i].is_rd)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), q & VECS[i].mask,
                      VECS[i].data & VECS[i].mask);
        end

        // R3 / R4: fill, overflow, clear
        for (int i = 0; i < DEPTH; i++) wr(1'b0, 2'd2, 32'hA000_0000 + i);
        rd(1'b0, 2'd1, q); check("R3 A tx full", q & 32'h3, 32'h2);
        rd(1'b1, 2'd1, q); check("R3 B rx full", q & 32'h300, 32'h200);
        wr(1'b0, 2'd2, 32'hDEAD_DEAD);
        rd(1'b0, 2'd1, q); check("R4 err set", q & 32'h4000, 32'h4000);
        wr(1'b0, 2'd1, 32'h0000_C000);
        rd(1'b0, 2'd1, q); check("R4 err cleared", q & 32'hC000, 32'h8000);
        for (int i = 0; i < DEPTH; i++) begin
            rd(1'b1, 2'd3, q); check("R4 R2 drain order", q, 32'hA000_0000 + i);
        end
        rd(1'b1, 2'd1, q); check("R3 B rx empty", q & 32'h300, 32'h100);

        // R5 underflow
        rd(1'b1, 2'd3, q); check("R5 last word", q, 32'hA000_000F);
        rd(1'b1, 2'd1, q); check("R5 err", q & 32'h4100, 32'h4100);
        wr(1'b0, 2'd2, 32'h0000_0077);
        rd(1'b1, 2'd3, q); check("R5 pointers kept", q, 32'h0000_0077);
        rd(1'b1, 2'd1, q); check("R5 empty again", q & 32'h100, 32'h100);
        wr(1'b1, 2'd1, 32'h0000_C000);

        // R6 disabled queues
        wr(1'b1, 2'd1, 32'h0);
        wr(1'b0, 2'd2, 32'h0000_0099);
        rd(1'b1, 2'd3, q); check("R6 head visible", q, 32'h0000_0099);
        rd(1'b1, 2'd1, q); check("R6 no pop no err", q & 32'h4100, 32'h0);
        wr(1'b1, 2'd2, 32'h0000_0055);
        rd(1'b0, 2'd1, q); check("R6 no push", q & 32'h100, 32'h100);
        wr(1'b1, 2'd1, 32'h0000_8000);
        rd(1'b1, 2'd3, q); check("R6 re-enabled pop", q, 32'h0000_0099);
        rd(1'b1, 2'd1, q); check("R6 drained", q & 32'h100, 32'h100);

        // R7 flush
        for (int i = 0; i < 3; i++) wr(1'b0, 2'd2, 32'hF000_0000 + i);
        wr(1'b0, 2'd1, 32'h0000_8000);
        rd(1'b1, 2'd1, q); check("R7 bit3=0 keeps", q & 32'h100, 32'h0);
        wr(1'b0, 2'd1, 32'h0000_8008);
        rd(1'b0, 2'd1, q); check("R7 A tx empty", q & 32'h1, 32'h1);
        rd(1'b1, 2'd1, q); check("R7 B rx empty", q & 32'h100, 32'h100);

        // R10 level interrupts
        wr(1'b0, 2'd1, 32'h0000_8004);
        check("R10 txe irq", {31'd0, a_irq}, 32'h1);
        wr(1'b0, 2'd1, 32'h0000_8000);
        check("R10 txe irq off", {31'd0, a_irq}, 32'h0);
        wr(1'b1, 2'd1, 32'h0000_8400);
        check("R10 rxne idle", {31'd0, b_irq}, 32'h0);
        wr(1'b0, 2'd2, 32'h0000_1234);
        check("R10 rxne irq", {31'd0, b_irq}, 32'h1);
        rd(1'b1, 2'd3, q);
        check("R10 rxne cleared", {31'd0, b_irq}, 32'h0);
        wr(1'b1, 2'd1, 32'h0000_8000);

        // R9 doorbells
        acc(1'b1, 1'b0, 2'd0, 4'h8, 32'h8000_0000, q);
        rd(1'b1, 2'd0, q); check("R9 enable bit", q & 32'h8000_0000, 32'h8000_0000);
        acc(1'b0, 1'b0, 2'd0, 4'h8, 32'h2000_0000, q);
        check("R9 B pulse", {31'd0, b_irq}, 32'h1);
        @(posedge clk); #1;
        check("R9 B pulse one cycle", {31'd0, b_irq}, 32'h0);
        acc(1'b0, 1'b0, 2'd0, 4'h8, 32'h4000_0000, q);
        check("R9 wrong ring bit", {31'd0, b_irq}, 32'h0);
        acc(1'b1, 1'b0, 2'd0, 4'h8, 32'hC000_0000, q);
        check("R9 A gated", {31'd0, a_irq}, 32'h0);
        acc(1'b0, 1'b0, 2'd0, 4'h8, 32'h8000_0000, q);
        acc(1'b1, 1'b0, 2'd0, 4'h8, 32'hC000_0000, q);
        check("R9 A pulse", {31'd0, a_irq}, 32'h1);
        @(posedge clk); #1;
        check("R9 A pulse one cycle", {31'd0, a_irq}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule